// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block puts one low-speed USB packet on the D+/D- pair. A single-cycle start pulse together with a byte count begins the packet. The count includes the sync byte, which the block makes itself. Before the drivers are enabled, the block presets the lines to the idle J state. It then sends the sync pattern and the buffered bytes, least significant bit first. Each bit takes eight clock cycles of a 12 MHz clock, and the line is NRZI-encoded with stuffed bits inserted as needed. The packet closes with two bit times of SE0, then one bit time of J. The drivers are then released, with both lines low so that no pull-up stays active.

The payload comes from an external buffer through a read-address and read-data pair. No CRC is generated here, so the buffer must already hold the PID, the payload and the CRC. The block also owns the device-address register. A pending new address is committed only at the end of a packet longer than a bare handshake. A sticky flag records receive-start events, and the block clears it when the end-of-packet begins.

Top module: `ls_usb_tx`

## Requirements
- R1: After reset, oe_o, dp_o, dm_o, busy_o, done_o and rx_flag_o are 0, and dev_addr_o is 0.
- R2: In the cycle after start_i is sampled while idle, the lines show J (dp_o=0, dm_o=1) with oe_o=0. oe_o rises in the next cycle, together with the first bit.
- R3: The first byte sent is 0x80, LSb first, which gives seven toggles and then a hold. Buffer entry k (at rd_addr_o=k) is sent as byte k+1 after the sync byte, so byte_cnt_i-1 buffer bytes are sent. A count of 0 or 1 sends the sync byte alone. rd_data_i is sampled at least eight cycles after rd_addr_o settles.
- R4: Every line state lasts 8 cycles. A 0 bit toggles between J and K and a 1 bit holds the line. K is dp_o=1, dm_o=0.
- R5: After six 1 bits in a row, one extra toggle is inserted. The run count resets on any 0 bit or stuffed bit and carries across byte boundaries. A run that ends the packet is also stuffed before the EOP.
- R6: After the last bit, the block drives SE0 (both lines 0, oe_o=1) for 16 cycles and then J for 8 cycles. Next, oe_o, dp_o and dm_o go to 0 and done_o pulses for one cycle.
- R7: If byte_cnt_i > 2 and new_addr_vld_i is high when SE0 begins, dev_addr_o takes new_addr_i in the first SE0 cycle, and SE0 then lasts 17 cycles.
- R8: For a count of 2 or less, or with no pending address, dev_addr_o keeps its value.
- R9: rx_evt_i sets rx_flag_o, which stays set while idle. It is cleared in the first SE0 cycle of the next packet.
- R10: busy_o is high from the cycle after start until done_o. A start pulse while busy has no effect on the lines.
- R11: dp_o and dm_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken while idle |
| byte_cnt_i | input | CNT_W | Bytes in packet including sync |
| rd_addr_o | output | CNT_W | Buffer read address |
| rd_data_i | input | 8 | Buffer read data |
| new_addr_vld_i | input | 1 | A new device address is pending |
| new_addr_i | input | ADDR_W | Pending device address |
| rx_evt_i | input | 1 | Receive-start event |
| dp_o | output | 1 | D+ drive value |
| dm_o | output | 1 | D- drive value |
| oe_o | output | 1 | Output driver enable |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse after the bus is released |
| dev_addr_o | output | ADDR_W | Current device address |
| rx_flag_o | output | 1 | Sticky receive-start flag |

## Verification
A handshake-sized packet and several data packets are compared line state by line state against a model built in the bench. Payloads rich in zeros exercise the NRZI toggling. Long runs of ones split across a byte boundary, including one that ends the packet, show whether the run count carries over and whether the final stuffed bit is inserted. Sync-only counts and a repeated start mid-packet probe the count edge cases and the ignore rule. Address commits with and without a pending address, at counts on either side of the handshake size, distinguish the 16-cycle SE0 from the stretched 17-cycle SE0.

// File: rtl/lstx_pkg.sv
package lstx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DATA,
    ST_SE0,
    ST_EOPJ
  } tx_state_e;

  typedef enum logic [2:0] {
    LN_REL,
    LN_PREJ,
    LN_BIT,
    LN_SE0,
    LN_J
  } line_mode_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/lstx_bit_timer.sv
module lstx_bit_timer #(
  parameter int TMR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [TMR_W-1:0] limit,
  output logic             last
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == limit);
endmodule

// File: rtl/lstx_byte_feed.sv
module lstx_byte_feed
  import lstx_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  count,
  input  logic              consume,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_addr,
  output logic              cur_bit,
  output logic              valid
);
  localparam int BIDX_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [CNT_W-1:0]  addr_q, addr_d;
  logic              valid_q, valid_d;

  always_comb begin
    shift_d = shift_q;
    bidx_d  = bidx_q;
    left_d  = left_q;
    addr_d  = addr_q;
    valid_d = valid_q;
    if (load) begin
      shift_d = BYTE_W'(SYNC_BYTE);
      bidx_d  = '0;
      left_d  = (count > CNT_W'(1)) ? (count - CNT_W'(1)) : '0;
      addr_d  = '0;
      valid_d = 1'b1;
    end else if (consume) begin
      if (bidx_q == BIDX_W'(BYTE_W - 1)) begin
        if (left_q != '0) begin
          shift_d = rd_data;
          addr_d  = addr_q + CNT_W'(1);
          left_d  = left_q - CNT_W'(1);
          bidx_d  = '0;
        end else begin
          valid_d = 1'b0;
        end
      end else begin
        shift_d = {1'b0, shift_q[BYTE_W-1:1]};
        bidx_d  = bidx_q + BIDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bidx_q  <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      shift_q <= shift_d;
      bidx_q  <= bidx_d;
      left_q  <= left_d;
      addr_q  <= addr_d;
      valid_q <= valid_d;
    end
  end

  assign rd_addr = addr_q;
  assign cur_bit = shift_q[0];
  assign valid   = valid_q;
endmodule

// File: rtl/lstx_stuffer.sv
module lstx_stuffer #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic bit_in,
  output logic stuff_now
);
  localparam int OW = $clog2(STUFF_RUN + 1);

  logic [OW-1:0] ones_q, ones_d;

  assign stuff_now = (ones_q == OW'(STUFF_RUN));

  always_comb begin
    ones_d = ones_q;
    if (clr) begin
      ones_d = '0;
    end else if (step) begin
      if (stuff_now)   ones_d = '0;
      else if (bit_in) ones_d = ones_q + OW'(1);
      else             ones_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end
endmodule

// File: rtl/lstx_line.sv
module lstx_line
  import lstx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  line_mode_e mode,
  input  logic       toggle,
  output logic       oe,
  output logic       dp,
  output logic       dm
);
  logic lvl_q, lvl_d;
  logic oe_q, oe_d, dp_q, dp_d, dm_q, dm_d;

  always_comb begin
    lvl_d = lvl_q;
    oe_d  = oe_q;
    dp_d  = dp_q;
    dm_d  = dm_q;
    if (upd) begin
      case (mode)
        LN_PREJ: begin
          lvl_d = 1'b1;
          oe_d  = 1'b0;
          dp_d  = 1'b0;
          dm_d  = 1'b1;
        end
        LN_BIT: begin
          lvl_d = lvl_q ^ toggle;
          oe_d  = 1'b1;
          dp_d  = ~(lvl_q ^ toggle);
          dm_d  = lvl_q ^ toggle;
        end
        LN_SE0: begin
          oe_d = 1'b1;
          dp_d = 1'b0;
          dm_d = 1'b0;
        end
        LN_J: begin
          oe_d = 1'b1;
          dp_d = 1'b0;
          dm_d = 1'b1;
        end
        default: begin
          lvl_d = 1'b1;
          oe_d  = 1'b0;
          dp_d  = 1'b0;
          dm_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      oe_q  <= 1'b0;
      dp_q  <= 1'b0;
      dm_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      oe_q  <= oe_d;
      dp_q  <= dp_d;
      dm_q  <= dm_d;
    end
  end

  assign oe = oe_q;
  assign dp = dp_q;
  assign dm = dm_q;
endmodule

// File: rtl/ls_usb_tx.sv
module ls_usb_tx
  import lstx_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int ADDR_W    = 7,
  parameter int BIT_CYC   = 8,
  parameter int SE0_BITS  = 2,
  parameter int STUFF_RUN = 6,
  parameter int HS_BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  output logic [CNT_W-1:0]  rd_addr_o,
  input  logic [7:0]        rd_data_i,
  input  logic              new_addr_vld_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  input  logic              rx_evt_i,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] dev_addr_o
  ,output logic             rx_flag_o
);
  localparam int SE0_CYC = SE0_BITS * BIT_CYC;
  localparam int TMR_W   = $clog2(SE0_CYC + BIT_CYC + 1);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              stretch_q, stretch_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rxf_q, rxf_d;
  logic              done_q, done_d;

  logic             load, slot_go, se0_go, j_go, rel_go, commit;
  logic             tmr_last, tmr_en, tmr_clr;
  logic [TMR_W-1:0] tmr_limit;
  logic             cur_bit, feed_valid, stuff_now, more;
  line_mode_e       mode;
  logic             line_upd, toggle;

  lstx_bit_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .clr(tmr_clr),
    .limit(tmr_limit), .last(tmr_last)
  );

  lstx_byte_feed #(.CNT_W(CNT_W), .BYTE_W(8)) u_feed (
    .clk(clk), .rst_n(rst_n), .load(load), .count(byte_cnt_i),
    .consume(slot_go & ~stuff_now), .rd_data(rd_data_i),
    .rd_addr(rd_addr_o), .cur_bit(cur_bit), .valid(feed_valid)
  );

  lstx_stuffer #(.STUFF_RUN(STUFF_RUN)) u_stuff (
    .clk(clk), .rst_n(rst_n), .clr(load), .step(slot_go),
    .bit_in(cur_bit), .stuff_now(stuff_now)
  );

  lstx_line u_line (
    .clk(clk), .rst_n(rst_n), .upd(line_upd), .mode(mode),
    .toggle(toggle), .oe(oe_o), .dp(dp_o), .dm(dm_o)
  );

  assign more = feed_valid | stuff_now;

  always_comb begin
    case (state_q)
      ST_DATA, ST_EOPJ: tmr_limit = TMR_W'(BIT_CYC - 1);
      ST_SE0:           tmr_limit = stretch_q ? TMR_W'(SE0_CYC) : TMR_W'(SE0_CYC - 1);
      default:          tmr_limit = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    slot_go = 1'b0;
    se0_go  = 1'b0;
    j_go    = 1'b0;
    rel_go  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        load    = 1'b1;
        state_d = ST_PREP;
      end
      ST_PREP: begin
        slot_go = 1'b1;
        state_d = ST_DATA;
      end
      ST_DATA: if (tmr_last) begin
        if (more) slot_go = 1'b1;
        else begin
          se0_go  = 1'b1;
          state_d = ST_SE0;
        end
      end
      ST_SE0: if (tmr_last) begin
        j_go    = 1'b1;
        state_d = ST_EOPJ;
      end
      ST_EOPJ: if (tmr_last) begin
        rel_go  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_en  = (state_q != ST_IDLE);
  assign tmr_clr = load | slot_go | se0_go | j_go;
  assign commit  = se0_go & new_addr_vld_i & (cnt_q > CNT_W'(HS_BYTES));

  always_comb begin
    mode = LN_REL;
    if (load)         mode = LN_PREJ;
    else if (slot_go) mode = LN_BIT;
    else if (se0_go)  mode = LN_SE0;
    else if (j_go)    mode = LN_J;
  end
  assign line_upd = load | slot_go | se0_go | j_go | rel_go;
  assign toggle   = stuff_now | ~cur_bit;

  always_comb begin
    cnt_d     = load ? byte_cnt_i : cnt_q;
    stretch_d = se0_go ? commit : stretch_q;
    addr_d    = commit ? new_addr_i : addr_q;
    done_d    = rel_go;
    rxf_d     = rxf_q;
    if (se0_go)        rxf_d = 1'b0;
    else if (rx_evt_i) rxf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      stretch_q <= 1'b0;
      addr_q    <= '0;
      rxf_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      stretch_q <= stretch_d;
      addr_q    <= addr_d;
      rxf_q     <= rxf_d;
      done_q    <= done_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign dev_addr_o = addr_q;
  assign rx_flag_o  = rxf_q;
endmodule

// File: rtl/lstx_checker.sv
module lstx_checker #(
  parameter int BIT_CYC   = 8,
  parameter int STUFF_RUN = 6,
  parameter int ADDR_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dp,
  input logic              dm,
  input logic              oe,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              rx_flag
);
  localparam int MAXH = (STUFF_RUN + 1) * BIT_CYC;
  localparam int HW   = $clog2(MAXH + 2);

  logic [1:0]    prev_q;
  logic [HW-1:0] hold_q, hold_d;
  logic          drv;

  assign drv = oe & (dp | dm);

  always_comb begin
    hold_d = hold_q;
    if (!drv || ({dp, dm} != prev_q)) hold_d = '0;
    else if (hold_q != HW'(MAXH))     hold_d = hold_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      hold_q <= '0;
    end else begin
      prev_q <= {dp, dm};
      hold_q <= hold_d;
    end
  end

  assert_preset_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> ($past(dm) && !$past(dp)));

  assert_stuff_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q < HW'(MAXH));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!oe && !dp && !dm && $past(oe) && $past(dm) && !$past(dp)));

  assert_addr_in_se0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> (oe && !dp && !dm));

  assert_rx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_flag) |-> (oe && !dp && !dm));

  assert_oe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> busy);

  assert_no_se1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp && dm));
endmodule

bind ls_usb_tx lstx_checker #(
  .BIT_CYC(BIT_CYC), .STUFF_RUN(STUFF_RUN), .ADDR_W(ADDR_W)
) u_lstx_checker (
  .clk(clk), .rst_n(rst_n), .dp(dp_o), .dm(dm_o), .oe(oe_o),
  .busy(busy_o), .done(done_o), .dev_addr(dev_addr_o), .rx_flag(rx_flag_o)
);

// File: tb/test_ls_usb_tx.sv
module test_ls_usb_tx;
  localparam int CLK_PERIOD = 84;
  localparam int CNT_W  = 6;
  localparam int ADDR_W = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [CNT_W-1:0]  byte_cnt;
  logic [CNT_W-1:0]  rd_addr;
  logic [7:0]        rd_data;
  logic              new_addr_vld;
  logic [ADDR_W-1:0] new_addr;
  logic              rx_evt;
  logic              dp, dm, oe, busy, done, rx_flag;
  logic [ADDR_W-1:0] dev_addr;

  logic [7:0] mem [0:63];
  assign rd_data = mem[rd_addr];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ls_usb_tx i_ls_usb_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_cnt_i(byte_cnt),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .new_addr_vld_i(new_addr_vld),
    .new_addr_i(new_addr), .rx_evt_i(rx_evt), .dp_o(dp), .dm_o(dm),
    .oe_o(oe), .busy_o(busy), .done_o(done), .dev_addr_o(dev_addr),
    .rx_flag_o(rx_flag)
  );

  int    nchk = 0;
  int    nfail = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // expected item: {busy, done, oe, dp, dm, dev_addr}
  logic [11:0]       q[$];
  logic [ADDR_W-1:0] exp_addr = '0;
  logic              lvl;
  int                ones;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference stream
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [11:0] e;
      if (q.size() > 0) e = q.pop_front();
      else              e = {5'b00000, exp_addr};
      chk(cur_req, {busy, done, oe, dp, dm, dev_addr}, e);
      chk("R11", {31'd0, dp & dm}, 32'd0);
    end
  end

  task add_slot(input logic tog);
    if (tog) lvl = ~lvl;
    for (int c = 0; c < 8; c++) q.push_back({1'b1, 1'b0, 1'b1, ~lvl, lvl, exp_addr});
  endtask

  task add_bit(input logic b);
    add_slot(~b);                  // R4: zero toggles, one holds
    if (b) ones++; else ones = 0;
    if (ones == 6) begin           // R5: stuffed toggle
      add_slot(1'b1);
      ones = 0;
    end
  endtask

  task build(input int cnt, input logic pend, input logic [ADDR_W-1:0] na);
    logic [7:0] sync;
    int         s;
    sync = 8'h80;
    q.push_back({5'b00000, exp_addr});
    q.push_back({1'b1, 1'b0, 1'b0, 1'b0, 1'b1, exp_addr});   // R2 preset J
    lvl = 1'b1;
    ones = 0;
    for (int i = 0; i < 8; i++) add_bit(sync[i]);           // R3 sync first
    for (int k = 0; k < cnt - 1; k++)
      for (int i = 0; i < 8; i++) add_bit(mem[k][i]);
    if (cnt > 2 && pend) begin
      exp_addr = na;
      s = 17;
    end else begin
      s = 16;
    end
    for (int c = 0; c < s; c++) q.push_back({1'b1, 1'b0, 1'b1, 1'b0, 1'b0, exp_addr}); // R6
    for (int c = 0; c < 8; c++) q.push_back({1'b1, 1'b0, 1'b1, 1'b0, 1'b1, exp_addr});
    q.push_back({1'b0, 1'b1, 1'b0, 1'b0, 1'b0, exp_addr});
  endtask

  task automatic send(input int cnt, input logic pend, input logic [ADDR_W-1:0] na,
                      input string tag, input int poke, input int rx_at);
    cur_req = tag;
    @(posedge clk); #1;
    byte_cnt = cnt[CNT_W-1:0];
    new_addr_vld = pend;
    new_addr = na;
    start = 1'b1;
    build(cnt, pend, na);
    @(posedge clk); #1;
    start = 1'b0;
    if (rx_at > 0) begin
      repeat (rx_at) @(posedge clk);
      #1 rx_evt = 1'b1;
      @(posedge clk); #1 rx_evt = 1'b0;
      @(posedge clk); #1 chk("R9", {31'd0, rx_flag}, 32'd1);
    end
    if (poke > 0) begin            // R10: start while busy is ignored
      repeat (poke) @(posedge clk);
      #1 byte_cnt = 6'd1;
      start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      byte_cnt = cnt[CNT_W-1:0];
    end
    while (q.size() != 0) @(posedge clk);
    #1 new_addr_vld = 1'b0;
  endtask

  task finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    byte_cnt = '0;
    new_addr_vld = 1'b0;
    new_addr = '0;
    rx_evt = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1", {26'd0, oe, dp, dm, busy, done, rx_flag}, 32'd0);
    chk("R1", {25'd0, dev_addr}, 32'd0);

    // handshake with pending address: no commit (R8), preset (R2)
    mem[0] = 8'hD2;
    send(2, 1'b1, 7'h2A, "R8", 0, 0);
    chk("R8", {25'd0, dev_addr}, 32'd0);

    // data packet rich in zeros, address commit (R7), rx flag (R9, R4)
    mem[0] = 8'hC3; mem[1] = 8'h00; mem[2] = 8'h55; mem[3] = 8'h01;
    send(5, 1'b1, 7'h2A, "R7", 0, 40);
    chk("R7", {25'd0, dev_addr}, 32'h2A);
    chk("R9", {31'd0, rx_flag}, 32'd0);

    // rx event while idle stays set
    @(posedge clk); #1 rx_evt = 1'b1;
    @(posedge clk); #1 rx_evt = 1'b0;
    repeat (20) @(posedge clk);
    #1 chk("R9", {31'd0, rx_flag}, 32'd1);

    // runs of ones across bytes, stuffing at end (R5), start while busy (R10)
    mem[0] = 8'h4B; mem[1] = 8'hFF; mem[2] = 8'hFF; mem[3] = 8'hFC;
    send(5, 1'b0, 7'h11, "R5", 100, 0);
    chk("R8", {25'd0, dev_addr}, 32'h2A);
    chk("R9", {31'd0, rx_flag}, 32'd0);

    // sync only counts (R3)
    send(1, 1'b1, 7'h33, "R3", 0, 0);
    send(0, 1'b1, 7'h33, "R3", 0, 0);
    chk("R3", {25'd0, dev_addr}, 32'h2A);

    // three byte packet commits a second address (R7), end-of-packet form (R6)
    mem[0] = 8'h69; mem[1] = 8'h7E;
    send(3, 1'b1, 7'h15, "R6", 0, 0);
    chk("R7", {25'd0, dev_addr}, 32'h15);

    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule